// File: doc/BRIEF.md
# Power Rail Sequencer with Retry

This controller switches on a row of output supply rails in a fixed order. Sequencing begins only while the input supply is reported present. Each rail's enable is raised only after the rail before it reports power-good. If a rail does not report power-good within a bounded number of cycles, the controller treats that as an error.

The controller then performs an ordered shutdown, dropping the rails from the last enabled one back to the first, one per cycle. Three conditions start this shutdown: the input supply going away, a rail that was already confirmed good losing power-good, or an overvoltage or undervoltage fault flag whose shutdown enable is set. A shutdown caused by a fault, by loss of power-good or by a timeout leads to a delayed restart. The number of restarts is bounded by a configured limit. When the limit is used up, the controller parks in a latched failed state. Only a clear command that carries a data write releases it. A bare command with no data is ignored.

The fault flags come from an external threshold detector. The rail enables drive the regulators. The state code is there for observation only.

Top module: `rseq_ctrl`

## Requirements
- R1: With all rails off, rail 0 is enabled on the first clock edge at which `vin_on` is sampled high, and never while `vin_on` is low.
- R2: Rail i+1 is enabled on the clock edge at which rail i, while being brought up, has its `rail_pg` sampled high. No higher rail is ever enabled without the rail below it having reported power-good.
- R3: `vin_on` low while sequencing up or fully on starts a shutdown. Once it completes, the controller returns to idle (`seq_state` 0) with no delay and without using a retry. The same shutdown starts when a rail that has already reported power-good loses it, but in that case a retry follows.
- R4: A set bit in `ov_flt` starts a shutdown only while `cfg_ov_dn_en` is 1, and a set bit in `uv_flt` only while `cfg_uv_dn_en` is 1. Otherwise these flags have no effect.
- R5: Shutdown holds the enables unchanged for one cycle (`seq_state` 3). It then clears one enable per clock, from the highest enabled rail down to rail 0. At most one enable bit changes on any clock edge.
- R6: If the rail being brought up has not reported power-good PG_TIMEOUT cycles after its enable rose, the controller shuts down and schedules a retry.
- R7: After a shutdown that needs a retry, the controller waits with all rails off (`seq_state` 4) for exactly RETRY_DELAY+1 cycles before it returns to idle and can restart. At most `cfg_retry_max` retries follow the first attempt.
- R8: When a shutdown needs a retry but the limit is used up, `failed` goes to 1, `seq_state` goes to 5, and all enables stay 0 for as long as the state lasts.
- R9: The failed state is left, to idle, only on an edge where `clr_stb` and `clr_wr` are both 1. A strobe with `clr_wr` 0 (a bare command) leaves it failed.
- R10: The retry count returns to zero each time all rails reach power-good (`seq_state` 2). Repeated isolated errors separated by successful power-ups therefore never lead to the failed state.
- R11: `seq_state` encodes idle 0, powering up 1, all on 2, shutting down 3, retry wait 4, failed 5. `busy` is 1 exactly in codes 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_on | input | 1 | Input supply reported present |
| rail_pg | input | N | Per-rail power-good |
| ov_flt | input | N | Per-rail overvoltage fault flags |
| uv_flt | input | N | Per-rail undervoltage fault flags |
| cfg_ov_dn_en | input | 1 | Overvoltage faults cause shutdown |
| cfg_uv_dn_en | input | 1 | Undervoltage faults cause shutdown |
| cfg_retry_max | input | TRY_W | Number of allowed restart attempts |
| clr_stb | input | 1 | Clear command strobe |
| clr_wr | input | 1 | Clear command carries a data write |
| rail_en | output | N | Per-rail enables, bit 0 first in power-up order |
| busy | output | 1 | Sequencing, shutting down or waiting to retry |
| seq_state | output | 3 | Controller state code |
| failed | output | 1 | Latched failure after retries are used up |

## Verification
Two decisions can land on the same clock edge: the input supply going away and an enabled undervoltage fault. The first alone ends in idle with no retry, and the second alone schedules a retry. The bench drops `vin_on` and raises a `uv_flt` bit within the same cycle. It judges the result by the state reached after the ordered shutdown, which must be the retry wait and not idle. A second overlap, a bare clear strobe in the failed state, is judged by `failed` staying 1.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_UP   = 3'd1,
        S_ON   = 3'd2,
        S_DOWN = 3'd3,
        S_WAIT = 3'd4,
        S_FAIL = 3'd5
    } rseq_state_e;
endpackage

// File: rtl/rseq_timer.sv
module rseq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R7: an idle expired timer never wraps around to a large count
    assert_timer_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rseq_fault_merge.sv
module rseq_fault_merge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         vin_on,
    input  logic [N-1:0] pg,
    input  logic [N-1:0] good,
    input  logic [N-1:0] ov,
    input  logic [N-1:0] uv,
    input  logic         ov_en,
    input  logic         uv_en,
    input  logic         tmo,
    output logic         stop,
    output logic         retry
);
    logic pg_lost, ov_hit, uv_hit, retry_cause;

    always_comb begin
        pg_lost     = |(good & ~pg);
        ov_hit      = ov_en && (|ov);
        uv_hit      = uv_en && (|uv);
        retry_cause = pg_lost || ov_hit || uv_hit || tmo;
        stop        = active && (!vin_on || retry_cause);
        retry       = retry_cause;
    end

    // R4: disabled fault classes alone never stop the sequence
    assert_masked_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ov_en && !uv_en && vin_on && !tmo && (good & ~pg) == '0) |-> !stop);
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int N           = 4,
    parameter int PG_TIMEOUT  = 16,
    parameter int RETRY_DELAY = 8,
    parameter int TRY_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin_on,
    input  logic [N-1:0]     rail_pg,
    input  logic [N-1:0]     ov_flt,
    input  logic [N-1:0]     uv_flt,
    input  logic             cfg_ov_dn_en,
    input  logic             cfg_uv_dn_en,
    input  logic [TRY_W-1:0] cfg_retry_max,
    input  logic             clr_stb,
    input  logic             clr_wr,
    output logic [N-1:0]     rail_en,
    output logic             busy,
    output logic [2:0]       seq_state,
    output logic             failed
);
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1;
    localparam int TMR_MAX = (PG_TIMEOUT > RETRY_DELAY) ? PG_TIMEOUT : RETRY_DELAY;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        rseq_state_e        st;
        logic [N-1:0]       en;
        logic [N-1:0]       good;
        logic [IDX_W-1:0]   idx;
        logic [TRY_W-1:0]   tries;
        logic               retry;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             err_stop, err_retry;

    rseq_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    rseq_fault_merge #(.N(N)) i_faults (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (r_q.st == S_UP || r_q.st == S_ON),
        .vin_on (vin_on),
        .pg     (rail_pg),
        .good   (r_q.good),
        .ov     (ov_flt),
        .uv     (uv_flt),
        .ov_en  (cfg_ov_dn_en),
        .uv_en  (cfg_uv_dn_en),
        .tmo    (r_q.st == S_UP && tmr_done),
        .stop   (err_stop),
        .retry  (err_retry)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            S_IDLE: begin
                if (vin_on) begin
                    r_d.st    = S_UP;
                    r_d.idx   = '0;
                    r_d.en[0] = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PG_TIMEOUT);
                end
            end
            S_UP: begin
                if (err_stop) begin
                    r_d.st    = S_DOWN;
                    r_d.retry = err_retry;
                end else if (rail_pg[r_q.idx]) begin
                    r_d.good[r_q.idx] = 1'b1;
                    if (r_q.idx == LAST) begin
                        r_d.st    = S_ON;
                        r_d.tries = '0;
                    end else begin
                        r_d.idx         = r_q.idx + IDX_W'(1);
                        r_d.en[r_d.idx] = 1'b1;
                        tmr_load        = 1'b1;
                        tmr_val         = TMR_W'(PG_TIMEOUT);
                    end
                end
            end
            S_ON: begin
                if (err_stop) begin
                    r_d.st    = S_DOWN;
                    r_d.retry = err_retry;
                end
            end
            S_DOWN: begin
                r_d.en[r_q.idx]   = 1'b0;
                r_d.good[r_q.idx] = 1'b0;
                if (r_q.idx == '0) begin
                    if (!r_q.retry) begin
                        r_d.st = S_IDLE;
                    end else if (r_q.tries < cfg_retry_max) begin
                        r_d.st    = S_WAIT;
                        r_d.tries = r_q.tries + TRY_W'(1);
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(RETRY_DELAY);
                    end else begin
                        r_d.st = S_FAIL;
                    end
                end else begin
                    r_d.idx = r_q.idx - IDX_W'(1);
                end
            end
            S_WAIT: begin
                if (tmr_done) r_d.st = S_IDLE;
            end
            S_FAIL: begin
                if (clr_stb && clr_wr) begin
                    r_d.st    = S_IDLE;
                    r_d.tries = '0;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= S_IDLE;
            r_q.en    <= '0;
            r_q.good  <= '0;
            r_q.idx   <= '0;
            r_q.tries <= '0;
            r_q.retry <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rail_en   = r_q.en;
    assign seq_state = r_q.st;
    assign failed    = (r_q.st == S_FAIL);
    assign busy      = (r_q.st == S_UP) || (r_q.st == S_DOWN) || (r_q.st == S_WAIT);

    // R1: rail 0 only rises after the input supply was seen present
    assert_first_rail_needs_vin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[0]) |-> $past(vin_on));

    // R5: at most one enable changes per clock
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    // R8: failed state keeps every rail dark
    assert_failed_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (rail_en == '0));

    // R9: without a data-carrying clear the failed state persists
    assert_clear_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (failed && !(clr_stb && clr_wr)) |=> failed);

    // R7: retry counter never exceeds the configured limit
    assert_tries_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tries <= cfg_retry_max);

    for (genvar i = 1; i < N; i++) begin : g_order
        // R2: a higher rail rises only after the rail below reported good
        assert_next_after_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[i]) |-> $past(rail_pg[i-1]));
        // R5: a rail falls only once every rail above it is already off
        assert_reverse_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rail_en[i-1]) |-> !rail_en[i]);
    end
endmodule

// File: tb/test_rseq_ctrl.sv
`timescale 1ns/1ps
module test_rseq_ctrl;
    localparam int N    = 4;
    localparam int PGTO = 16;
    localparam int RDLY = 8;
    localparam int TW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vin_on = 1'b0;
    logic [N-1:0]  rail_pg;
    logic [N-1:0]  ov_flt = '0, uv_flt = '0;
    logic          cfg_ov_dn_en = 1'b0, cfg_uv_dn_en = 1'b0;
    logic [TW-1:0] cfg_retry_max = 3'd2;
    logic          clr_stb = 1'b0, clr_wr = 1'b0;
    logic [N-1:0]  rail_en;
    logic          busy, failed;
    logic [2:0]    seq_state;
    logic [N-1:0]  allow = '1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // simple rail model: power-good follows the enable one clock later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) rail_pg <= '0;
        else        rail_pg <= rail_en & allow;
    end

    rseq_ctrl #(.N(N), .PG_TIMEOUT(PGTO), .RETRY_DELAY(RDLY), .TRY_W(TW)) i_rseq_ctrl (
        .clk(clk), .rst_n(rst_n), .vin_on(vin_on), .rail_pg(rail_pg),
        .ov_flt(ov_flt), .uv_flt(uv_flt), .cfg_ov_dn_en(cfg_ov_dn_en),
        .cfg_uv_dn_en(cfg_uv_dn_en), .cfg_retry_max(cfg_retry_max),
        .clr_stb(clr_stb), .clr_wr(clr_wr), .rail_en(rail_en), .busy(busy),
        .seq_state(seq_state), .failed(failed)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input logic [2:0] s, input int max);
        for (int k = 0; k < max && seq_state != s; k++) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vin_on = 1'b0; allow = '1; ov_flt = '0; uv_flt = '0;
        cfg_ov_dn_en = 1'b0; cfg_uv_dn_en = 1'b0; clr_stb = 1'b0; clr_wr = 1'b0;
        step(2);
        rst_n = 1'b1;
        step();
    endtask

    task automatic bring_up();
        vin_on = 1'b1;
        wait_state(3'd2, 500);
    endtask

    task automatic t_reset_and_powerup();
        do_reset();
        step(3);
        check(rail_en == 0 && seq_state == 0 && !busy && !failed, "R1 idle without vin", int'(rail_en), 0);
        vin_on = 1'b1;
        step();
        check(rail_en == 4'b0001, "R1 rail0 after vin", int'(rail_en), 1);
        check(seq_state == 1 && busy, "R11 up code", int'(seq_state), 1);
        step(2);
        check(rail_en == 4'b0011, "R2 rail1 after pg0", int'(rail_en), 3);
        step(2);
        check(rail_en == 4'b0111, "R2 rail2 after pg1", int'(rail_en), 7);
        step(2);
        check(rail_en == 4'b1111, "R2 rail3 after pg2", int'(rail_en), 15);
        step(2);
        check(seq_state == 2 && !busy, "R11 all-on code", int'(seq_state), 2);
    endtask

    task automatic t_vin_off();
        do_reset();
        bring_up();
        vin_on = 1'b0;
        step();
        check(seq_state == 3 && rail_en == 4'b1111, "R3 shutdown on vin loss", int'(seq_state), 3);
        step();
        check(rail_en == 4'b0111, "R5 top rail first", int'(rail_en), 7);
        step();
        check(rail_en == 4'b0011, "R5 rail2 next", int'(rail_en), 3);
        step();
        check(rail_en == 4'b0001, "R5 rail1 next", int'(rail_en), 1);
        step();
        check(rail_en == 0 && seq_state == 0, "R3 vin loss ends idle", int'(seq_state), 0);
        step(5);
        check(seq_state == 0 && rail_en == 0, "R1 stays idle without vin", int'(seq_state), 0);
    endtask

    task automatic t_fault_masking();
        int wcnt;
        do_reset();
        bring_up();
        ov_flt = 4'b0010; uv_flt = 4'b0100;
        step();
        ov_flt = '0; uv_flt = '0;
        step();
        check(seq_state == 2 && rail_en == 4'b1111, "R4 masked faults ignored", int'(seq_state), 2);
        cfg_ov_dn_en = 1'b1;
        uv_flt = 4'b0001;
        step();
        uv_flt = '0;
        step();
        check(seq_state == 2, "R4 uv still masked", int'(seq_state), 2);
        ov_flt = 4'b1000;
        step();
        ov_flt = '0;
        check(seq_state == 3 && rail_en == 4'b1111, "R4 enabled ov stops", int'(seq_state), 3);
        step(4);
        check(rail_en == 0 && seq_state == 4, "R7 fault leads to wait", int'(seq_state), 4);
        wcnt = 0;
        for (int k = 0; k < 100 && seq_state == 4; k++) begin
            wcnt++;
            check(rail_en == 0, "R7 rails off in wait", int'(rail_en), 0);
            step();
        end
        check(wcnt == RDLY + 1, "R7 wait length", wcnt, RDLY + 1);
        check(seq_state == 0, "R7 wait returns idle", int'(seq_state), 0);
        wait_state(3'd2, 500);
        check(seq_state == 2 && rail_en == 4'b1111, "R7 retry powers up", int'(rail_en), 15);
    endtask

    task automatic t_timeout_fail_clear();
        int ups, first_up;
        logic [2:0] prev;
        do_reset();
        allow = 4'b1101;
        vin_on = 1'b1;
        ups = 0; first_up = 0; prev = seq_state;
        for (int k = 0; k < 3000 && seq_state != 5; k++) begin
            if (prev != 1 && seq_state == 1) ups++;
            if (ups == 1 && seq_state == 1) first_up++;
            prev = seq_state;
            step();
        end
        check(first_up >= PGTO && first_up <= PGTO + 2 * N + 1, "R6 timeout window", first_up, PGTO + 3);
        check(ups == int'(cfg_retry_max) + 1, "R7 attempt count", ups, int'(cfg_retry_max) + 1);
        check(failed && seq_state == 5 && rail_en == 0, "R8 latched failed", int'(seq_state), 5);
        step(10);
        check(failed && rail_en == 0, "R8 failed persists", int'(failed), 1);
        allow = '1;
        clr_stb = 1'b1; clr_wr = 1'b0;
        step();
        clr_stb = 1'b0;
        step();
        check(failed && seq_state == 5, "R9 bare clear ignored", int'(seq_state), 5);
        clr_stb = 1'b1; clr_wr = 1'b1;
        step();
        clr_stb = 1'b0; clr_wr = 1'b0;
        check(!failed && seq_state == 0, "R9 write clear releases", int'(seq_state), 0);
        wait_state(3'd2, 500);
        check(seq_state == 2, "R9 restart after clear", int'(seq_state), 2);
    endtask

    task automatic t_counter_reset();
        do_reset();
        bring_up();
        for (int r = 0; r < 4; r++) begin
            allow[3] = 1'b0;
            step();
            allow[3] = 1'b1;
            step();
            check(seq_state == 3, "R3 pg loss starts shutdown", int'(seq_state), 3);
            wait_state(3'd2, 500);
            check(seq_state == 2 && !failed, "R10 counter reset on success", int'(failed), 0);
        end
    endtask

    task automatic t_collision();
        do_reset();
        cfg_uv_dn_en = 1'b1;
        bring_up();
        vin_on = 1'b0;
        uv_flt = 4'b0001;
        step();
        uv_flt = '0;
        check(seq_state == 3, "R3 collision shuts down", int'(seq_state), 3);
        step(4);
        check(seq_state == 4 && rail_en == 0, "R4 fault wins over vin loss", int'(seq_state), 4);
        step(RDLY + 4);
        check(seq_state == 0 && rail_en == 0, "R1 no restart without vin", int'(seq_state), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_and_powerup();
        t_vin_off();
        t_fault_masking();
        t_timeout_fail_clear();
        t_counter_reset();
        t_collision();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule